// File: doc/BRIEF.md
# Bus Hold and Refresh Arbiter

This block decides when the local bus master hands the external address, data and control buses to an outside master. An asynchronous hold request from outside is synchronised to the bus clock. The block grants the buses only at a boundary between bus cycles, using a busy indication from the local bus sequencer. When it grants them, it turns off all three bus driver enables and raises hold acknowledge in the same cycle. When the request goes away, acknowledge drops first and the drivers come back one clock later.

The block also accepts periodic refresh ticks from an internal timer. While the block owns the bus, a tick starts a refresh cycle of fixed length, and the refresh request output stays high for that whole cycle. While the bus is held, a tick drives the refresh request output high so the outside master knows a refresh is due. That refresh is kept pending and runs as the first cycle after the bus comes back. An asynchronous wait input is captured on the falling clock edge, resynchronised, and passed to the sequencer. A stall output tells the sequencer not to start a new cycle.

Top module: `bus_hold_arb`

## Requirements
- R1: The hold request input passes through a two-stage synchroniser. When the bus is idle, a request first applied after rising edge E0 raises hold_ack after edge E3 and not after edge E2.
- R2: If cyc_busy is high in the cycle where the synchronised request is seen, the grant is deferred. hold_ack rises after the first rising edge at which cyc_busy is low. With no cycle in progress the grant takes a single edge.
- R3: In the cycle where hold_ack becomes 1, addr_oe, data_oe and ctrl_oe are all 0.
- R4: hold_ack stays 1 while the synchronised request is high. It falls on the edge after the synchronised request is seen low.
- R5: When hold_ack falls, the three driver enables stay 0 for that cycle and return to 1 one clock later, or at the start of a pending refresh (R9).
- R6: A request withdrawn before it is granted is cancelled. The block returns to owning the bus with the enables at 1, and hold_ack never pulses.
- R7: When the bus is owned, no cycle is busy and a refresh is pending, a refresh cycle of REF_LEN clocks runs. rfsh_req is 1 throughout, and the enables stay 1. A pending refresh takes precedence over a new hold request at an idle boundary.
- R8: A refresh tick while the bus is held sets rfsh_req to 1 on the next edge. rfsh_req stays 1 until hold_ack falls.
- R9: A refresh that becomes pending during hold runs as the first cycle after release. It starts on the edge after hold_ack falls, together with the return of the enables.
- R10: wait_in is sampled on the falling clock edge. seq_wait shows that sample after the following rising edge.
- R11: seq_stall is 1 whenever the block is not simply owning the bus, or the synchronised request is high, or a refresh is pending.
- R12: While reset is applied and right after it, the enables are 1 and hold_ack, rfsh_req, seq_stall and seq_wait are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_in | input | 1 | Asynchronous hold request from the outside master |
| wait_in | input | 1 | Asynchronous wait request that stretches the current cycle |
| cyc_busy | input | 1 | High while the sequencer has a bus cycle in progress |
| rfsh_tick | input | 1 | One-clock refresh demand from the refresh timer |
| addr_oe | output | 1 | Address bus driver enable |
| data_oe | output | 1 | Data bus driver enable |
| ctrl_oe | output | 1 | Control bus driver enable |
| hold_ack | output | 1 | Buses released to the outside master |
| rfsh_req | output | 1 | Refresh cycle running, or refresh due while held |
| seq_stall | output | 1 | Tells the sequencer not to start a new cycle |
| seq_wait | output | 1 | Synchronised wait to the sequencer |

## Verification
The bench builds the block with SYNC_STAGES=2 and REF_LEN=3. A three-clock refresh is short enough that refresh entry, its full length and its exit all fit in a few cycles. It can also be placed right next to a release, so a refresh queued during hold can be watched starting on the first cycle after the bus is regained. The two-stage synchroniser makes request and release latency exact edge counts, which the model predicts for grants, deferred grants and cancelled requests.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [2:0] {
        ST_OWN  = 3'd0,
        ST_PEND = 3'd1,
        ST_HELD = 3'd2,
        ST_REL  = 3'd3,
        ST_RFSH = 3'd4
    } bha_state_e;

    function automatic logic drives_bus(input bha_state_e st);
        return (st == ST_OWN) || (st == ST_PEND) || (st == ST_RFSH);
    endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bha_wait_sampler.sv
module bha_wait_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_in,
    output logic wait_out
);
    logic fall_d, fall_q;
    logic rise_d, rise_q;

    always_comb begin
        fall_d = wait_in;
        rise_d = fall_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fall_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= rise_d;
    end

    assign wait_out = rise_q;
endmodule

// File: rtl/bha_hold_fsm.sv
module bha_hold_fsm
    import bha_pkg::*;
#(
    parameter int REF_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hreq,
    input  logic cyc_busy,
    input  logic rfsh_tick,
    output logic addr_oe,
    output logic data_oe,
    output logic ctrl_oe,
    output logic hold_ack,
    output logic rfsh_req,
    output logic seq_stall
);
    localparam int CW = (REF_LEN > 1) ? $clog2(REF_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_LEN - 1);

    typedef struct packed {
        bha_state_e    st;
        logic          pend;
        logic [CW-1:0] cnt;
    } regs_t;

    regs_t d, q;
    logic  enter_rf;

    always_comb begin
        d        = q;
        enter_rf = 1'b0;
        case (q.st)
            ST_OWN: begin
                if (!cyc_busy && q.pend) begin
                    d.st     = ST_RFSH;
                    enter_rf = 1'b1;
                end else if (hreq) begin
                    d.st = cyc_busy ? ST_PEND : ST_HELD;
                end
            end
            ST_PEND: begin
                if (!hreq)          d.st = ST_OWN;
                else if (!cyc_busy) d.st = ST_HELD;
            end
            ST_HELD: begin
                if (!hreq) d.st = ST_REL;
            end
            ST_REL: begin
                if (q.pend) begin
                    d.st     = ST_RFSH;
                    enter_rf = 1'b1;
                end else begin
                    d.st = ST_OWN;
                end
            end
            ST_RFSH: begin
                if (q.cnt == '0) d.st  = ST_OWN;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_OWN;
        endcase
        if (enter_rf) begin
            d.cnt  = LAST;
            d.pend = rfsh_tick;
        end else begin
            d.pend = q.pend | rfsh_tick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_OWN, pend: 1'b0, cnt: '0};
        else        q <= d;
    end

    always_comb begin
        addr_oe   = drives_bus(q.st);
        data_oe   = drives_bus(q.st);
        ctrl_oe   = drives_bus(q.st);
        hold_ack  = (q.st == ST_HELD);
        rfsh_req  = (q.st == ST_RFSH) || ((q.st == ST_HELD) && q.pend);
        seq_stall = (q.st != ST_OWN) || hreq || q.pend;
    end

    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(!cyc_busy)); // R2

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hreq)); // R6

    AST_ACK_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> (!addr_oe && !data_oe && !ctrl_oe)); // R5

    AST_RFSH_AFTER_REGAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_ack) && q.pend) |=> (rfsh_req && addr_oe)); // R9

    AST_HELD_RFSH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && $past(hold_ack) && $past(rfsh_tick)) |-> rfsh_req); // R8
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb #(
    parameter int SYNC_STAGES = 2,
    parameter int REF_LEN     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_in,
    input  logic wait_in,
    input  logic cyc_busy,
    input  logic rfsh_tick,
    output logic addr_oe,
    output logic data_oe,
    output logic ctrl_oe,
    output logic hold_ack,
    output logic rfsh_req,
    output logic seq_stall,
    output logic seq_wait
);
    logic hreq_s;

    bha_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (hold_req_in),
        .dout (hreq_s)
    );

    bha_wait_sampler u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_in (wait_in),
        .wait_out(seq_wait)
    );

    bha_hold_fsm #(.REF_LEN(REF_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hreq     (hreq_s),
        .cyc_busy (cyc_busy),
        .rfsh_tick(rfsh_tick),
        .addr_oe  (addr_oe),
        .data_oe  (data_oe),
        .ctrl_oe  (ctrl_oe),
        .hold_ack (hold_ack),
        .rfsh_req (rfsh_req),
        .seq_stall(seq_stall)
    );
endmodule

// File: tb/bus_hold_arb_tb.sv
module bus_hold_arb_tb;
    localparam int RL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_in = 1'b0, wait_in = 1'b0, cyc_busy = 1'b0, rfsh_tick = 1'b0;
    logic addr_oe, data_oe, ctrl_oe, hold_ack, rfsh_req, seq_stall, seq_wait;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_hold_arb #(.SYNC_STAGES(2), .REF_LEN(RL)) u_dut (
        .clk(clk), .rst_n(rst_n), .hold_req_in(hold_req_in), .wait_in(wait_in),
        .cyc_busy(cyc_busy), .rfsh_tick(rfsh_tick), .addr_oe(addr_oe),
        .data_oe(data_oe), .ctrl_oe(ctrl_oe), .hold_ack(hold_ack),
        .rfsh_req(rfsh_req), .seq_stall(seq_stall), .seq_wait(seq_wait)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 own, 1 waiting, 2 held, 3 handing back, 4 refreshing
    int  m_mode = 0;
    int  m_left = 0;
    bit  m_due = 0;
    bit  m_hist[$] = '{0, 0};
    bit  m_wfall = 0;
    bit  m_wrise = 0;

    always @(negedge clk) m_wfall = rst_n ? wait_in : 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_due = 0; m_hist = '{0, 0}; m_wrise = 0;
        end else begin
            bit seen;
            bit start_rf;
            seen = m_hist[1];
            start_rf = 0;
            if (m_mode == 0) begin
                if (!cyc_busy && m_due) start_rf = 1;
                else if (seen) m_mode = cyc_busy ? 1 : 2;
            end else if (m_mode == 1) begin
                if (!seen) m_mode = 0;
                else if (!cyc_busy) m_mode = 2;
            end else if (m_mode == 2) begin
                if (!seen) m_mode = 3;
            end else if (m_mode == 3) begin
                if (m_due) start_rf = 1; else m_mode = 0;
            end else begin
                if (m_left == 1) m_mode = 0;
                else m_left--;
            end
            if (start_rf) begin
                m_mode = 4; m_left = RL; m_due = rfsh_tick;
            end else begin
                m_due = m_due | rfsh_tick;
            end
            m_hist.push_front(hold_req_in);
            void'(m_hist.pop_back());
            m_wrise = m_wfall;
        end
        #6;
        if (rst_n && !done) begin
            bit own;
            own = (m_mode == 0) || (m_mode == 1) || (m_mode == 4);
            chk("R3", "addr_oe", addr_oe, own);
            chk("R3", "data_oe", data_oe, own);
            chk("R3", "ctrl_oe", ctrl_oe, own);
            chk("R4", "hold_ack", hold_ack, m_mode == 2);
            chk("R7", "rfsh_req", rfsh_req, (m_mode == 4) || (m_mode == 2 && m_due));
            chk("R11", "seq_stall", seq_stall, (m_mode != 0) || m_hist[1] || m_due);
            chk("R10", "seq_wait", seq_wait, m_wrise);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(2);
        chk("R12", "addr_oe in reset", addr_oe, 1'b1);
        chk("R12", "hold_ack in reset", hold_ack, 1'b0);
        tick(1);
        rst_n = 1'b1;
        tick(1);
        chk("R12", "addr_oe", addr_oe, 1'b1);
        chk("R12", "hold_ack", hold_ack, 1'b0);
        chk("R12", "rfsh_req", rfsh_req, 1'b0);
        chk("R12", "seq_stall", seq_stall, 1'b0);
        chk("R12", "seq_wait", seq_wait, 1'b0);
        tick(1);

        // R1 R3 R4 R5: grant on an idle bus, then release
        hold_req_in = 1'b1;
        tick(2);
        chk("R1", "ack after two edges", hold_ack, 1'b0);
        tick(1);
        chk("R1", "ack after three edges", hold_ack, 1'b1);
        chk("R3", "addr_oe at grant", addr_oe, 1'b0);
        chk("R3", "data_oe at grant", data_oe, 1'b0);
        chk("R3", "ctrl_oe at grant", ctrl_oe, 1'b0);
        chk("R11", "stall while held", seq_stall, 1'b1);
        hold_req_in = 1'b0;
        tick(2);
        chk("R4", "ack held until sync low", hold_ack, 1'b1);
        tick(1);
        chk("R4", "ack dropped", hold_ack, 1'b0);
        chk("R5", "drivers still off", addr_oe, 1'b0);
        tick(1);
        chk("R5", "drivers back", addr_oe, 1'b1);
        chk("R11", "stall cleared", seq_stall, 1'b0);

        // R2: grant deferred by a busy cycle
        cyc_busy = 1'b1; hold_req_in = 1'b1;
        tick(3);
        chk("R2", "no grant while busy", hold_ack, 1'b0);
        chk("R2", "bus still driven", addr_oe, 1'b1);
        chk("R11", "stall while pending", seq_stall, 1'b1);
        tick(4);
        chk("R2", "still deferred", hold_ack, 1'b0);
        cyc_busy = 1'b0;
        tick(1);
        chk("R2", "grant at boundary", hold_ack, 1'b1);
        hold_req_in = 1'b0;
        tick(4);
        chk("R5", "owned again", addr_oe, 1'b1);

        // R6: withdrawn request
        cyc_busy = 1'b1; hold_req_in = 1'b1;
        tick(4);
        hold_req_in = 1'b0;
        tick(3);
        chk("R6", "stall gone after cancel", seq_stall, 1'b0);
        cyc_busy = 1'b0;
        tick(3);
        chk("R6", "no grant after cancel", hold_ack, 1'b0);
        chk("R6", "drivers on after cancel", addr_oe, 1'b1);

        // R7: refresh while owning
        rfsh_tick = 1'b1;
        tick(1);
        rfsh_tick = 1'b0;
        chk("R7", "not yet refreshing", rfsh_req, 1'b0);
        chk("R11", "stall with refresh due", seq_stall, 1'b1);
        tick(1);
        chk("R7", "refresh running", rfsh_req, 1'b1);
        chk("R7", "drivers on in refresh", addr_oe, 1'b1);
        tick(RL - 1);
        chk("R7", "refresh last clock", rfsh_req, 1'b1);
        tick(1);
        chk("R7", "refresh over", rfsh_req, 1'b0);

        // R8 R9: refresh due during hold
        hold_req_in = 1'b1;
        tick(3);
        chk("R8", "held", hold_ack, 1'b1);
        rfsh_tick = 1'b1;
        tick(1);
        rfsh_tick = 1'b0;
        chk("R8", "refresh flagged while held", rfsh_req, 1'b1);
        tick(3);
        chk("R8", "refresh flag stays", rfsh_req, 1'b1);
        hold_req_in = 1'b0;
        tick(2);
        chk("R8", "flag until release", rfsh_req, 1'b1);
        tick(1);
        chk("R5", "ack down drivers off", addr_oe, 1'b0);
        tick(1);
        chk("R9", "refresh first after regain", rfsh_req, 1'b1);
        chk("R9", "drivers back with refresh", addr_oe, 1'b1);
        tick(RL);
        chk("R9", "refresh done", rfsh_req, 1'b0);

        // R10: wait sampled on the falling edge
        wait_in = 1'b1;
        tick(1);
        chk("R10", "wait passed", seq_wait, 1'b1);
        wait_in = 1'b0;
        tick(1);
        chk("R10", "wait cleared", seq_wait, 1'b0);

        tick(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule